// File: doc/BRIEF.md
# Sobel Edge Binarizer

This block takes a raster stream of 8-bit grey pixels, one per clock when `pix_valid` is high, and produces for every interior pixel an edge strength and a one-bit black/white decision. Two row memories hold the two previous image lines. With the live pixel they give a 3x3 neighbourhood on each accepted pixel. Horizontal and vertical Sobel weights are applied tap by tap. Each window row is summed on its own, and a final adder combines the three row sums into each gradient.

The magnitude is the sum of the two absolute gradients, clipped to the 8-bit range. A strict comparison against a per-frame threshold turns it into the binary pixel: 1 is white, 0 is black. `frame_start` marks the first pixel of a frame and `line_start` marks the first pixel of every line. The threshold is captured only on the frame-start pixel, so all pixels of one frame are judged alike. Pixels whose window would reach outside the image produce no output.

Top module: `sobel_binarizer`

## Requirements
- R1: For an input pixel at row r, column c (r, c >= 2), the output describes centre (r-1, c-1). Window rows r-2 (top) to r and columns c-2 (left) to c give Gx = (right column, weights 1,2,1 top to bottom) minus (left column, same weights) and Gy = (bottom row, weights 1,2,1 left to right) minus (top row, same weights). `mag_out` = min(255, |Gx| + |Gy|).
- R2: Full-swing gradients of +1020 or -1020 on either axis are computed without wrap-around.
- R3: When |Gx| + |Gy| exceeds 255, `mag_out` is 255.
- R4: `bin_out` is 1 (white) exactly when `mag_out` is strictly greater than the frame threshold, and 0 (black) when it is equal or smaller.
- R5: The threshold is the value on `thresh_in` in the cycle of the valid frame-start pixel. Later changes to `thresh_in` have no effect until the next frame start.
- R6: Only input pixels with row >= 2 and column >= 2 produce `out_valid`; for a frame of R rows and C columns exactly (R-2)*(C-2) results appear, in raster order. While `out_valid` is low, `mag_out` and `bin_out` are 0.
- R7: A result appears on the outputs after the 6th rising edge, counting the edge that samples its last input pixel as the first.
- R8: `frame_start` sets the position to row 0, column 0. `line_start` sets the column to 0 and advances the row. Idle cycles with `pix_valid` low between pixels do not change any result.
- R9: After reset, `out_valid`, `mag_out` and `bin_out` are 0.
- R10: Lines of any length up to `LINE_W` (640 by default) are handled, including the last column of a full-width line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_in | input | 8 | Grey pixel value |
| pix_valid | input | 1 | Pixel present this cycle |
| frame_start | input | 1 | First pixel of a frame (with `pix_valid`) |
| line_start | input | 1 | First pixel of a line (with `pix_valid`) |
| thresh_in | input | 8 | Binarization threshold, taken at frame start |
| mag_out | output | 8 | Clipped gradient magnitude |
| bin_out | output | 1 | 1 when magnitude is above threshold |
| out_valid | output | 1 | Result present this cycle |

## Verification
The bench builds a step edge whose magnitude equals the threshold exactly. A comparator written as "greater or equal" would turn those pixels white. Full-swing 0/255 steps in both directions, plus a corner, stress the arithmetic: a signed path that is too narrow wraps the 1020 sums into small or negative values, and a missing clip shows the low bits of 1020. The threshold is changed in the middle of a frame, and pixels are sent with idle gaps, after a truncated frame and on a full 640-pixel line. A design that reads the threshold live, shifts the window on idle cycles, fails to restart the row count, or mis-addresses the row memories gives wrong magnitudes or a wrong result count.

// File: rtl/sobel_pkg.sv
`timescale 1ns/1ps
package sobel_pkg;

  localparam int WIN_DIM = 3;
  localparam int WIN_TAPS = WIN_DIM * WIN_DIM;

  typedef enum logic {
    GRAD_H = 1'b0,
    GRAD_V = 1'b1
  } grad_dir_e;

  // Tap index = WIN_DIM*row + col, row 0 = oldest line, col 0 = oldest pixel.
  function automatic int tap_weight(input grad_dir_e dir, input int idx);
    int r;
    int c;
    r = idx / WIN_DIM;
    c = idx % WIN_DIM;
    if (dir == GRAD_H) return (c - 1) * ((r == 1) ? 2 : 1);
    else               return (r - 1) * ((c == 1) ? 2 : 1);
  endfunction

endpackage

// File: rtl/sobel_line_store.sv
`timescale 1ns/1ps
module sobel_line_store #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 640
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [WIDTH-1:0]         wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [WIDTH-1:0]         rd_data
);

  logic [WIDTH-1:0] mem [DEPTH];

  // Read-first simple dual-port memory, suitable for block RAM.
  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
    if (wr_en) mem[wr_addr] <= wr_data;
  end

endmodule

// File: rtl/sobel_window.sv
`timescale 1ns/1ps
module sobel_window #(
  parameter int PIX_W  = 8,
  parameter int LINE_W = 640
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic [PIX_W-1:0]                        pix,
  input  logic                                    pix_v,
  input  logic [$clog2(LINE_W)-1:0]               col,
  output logic [sobel_pkg::WIN_TAPS*PIX_W-1:0]    win
);

  localparam int COL_W = $clog2(LINE_W);
  localparam int DIM   = sobel_pkg::WIN_DIM;

  logic             s1_v;
  logic [PIX_W-1:0] s1_pix;
  logic [COL_W-1:0] s1_col;
  logic [PIX_W-1:0] rd_mid;
  logic [PIX_W-1:0] rd_old;
  logic [PIX_W-1:0] fresh [DIM];
  logic [PIX_W-1:0] taps  [DIM][DIM];

  always_ff @(posedge clk) begin
    if (rst) s1_v <= 1'b0;
    else     s1_v <= pix_v;
    s1_pix <= pix;
    s1_col <= col;
  end

  // Previous line: written with the live pixel, read before overwrite.
  sobel_line_store #(.WIDTH(PIX_W), .DEPTH(LINE_W)) u_mid (
    .clk     (clk),
    .wr_en   (pix_v),
    .wr_addr (col),
    .wr_data (pix),
    .rd_addr (col),
    .rd_data (rd_mid)
  );

  // Line before that: fed from the previous-line read one cycle later.
  sobel_line_store #(.WIDTH(PIX_W), .DEPTH(LINE_W)) u_old (
    .clk     (clk),
    .wr_en   (s1_v),
    .wr_addr (s1_col),
    .wr_data (rd_mid),
    .rd_addr (col),
    .rd_data (rd_old)
  );

  assign fresh[0] = rd_old;
  assign fresh[1] = rd_mid;
  assign fresh[2] = s1_pix;

  for (genvar r = 0; r < DIM; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (s1_v) begin
        taps[r][0] <= taps[r][1];
        taps[r][1] <= taps[r][2];
        taps[r][2] <= fresh[r];
      end
    end
    for (genvar c = 0; c < DIM; c++) begin : g_col
      assign win[(DIM*r + c)*PIX_W +: PIX_W] = taps[r][c];
    end
  end

endmodule

// File: rtl/sobel_grad.sv
`timescale 1ns/1ps
module sobel_grad #(
  parameter int                   PIX_W = 8,
  parameter sobel_pkg::grad_dir_e DIR   = sobel_pkg::GRAD_H
) (
  input  logic                                 clk,
  input  logic [sobel_pkg::WIN_TAPS*PIX_W-1:0] win,
  output logic signed [PIX_W+3:0]              grad
);

  localparam int SUM_W = PIX_W + 4;
  localparam int DIM   = sobel_pkg::WIN_DIM;
  localparam int TAPS  = sobel_pkg::WIN_TAPS;

  logic signed [SUM_W-1:0] prod [TAPS];
  logic signed [SUM_W-1:0] rsum [DIM];

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    localparam logic signed [SUM_W-1:0] KW = SUM_W'(sobel_pkg::tap_weight(DIR, i));
    logic [PIX_W-1:0] px;
    assign px      = win[i*PIX_W +: PIX_W];
    assign prod[i] = KW * $signed({{(SUM_W-PIX_W){1'b0}}, px});
  end

  for (genvar r = 0; r < DIM; r++) begin : g_rsum
    always_ff @(posedge clk) begin
      rsum[r] <= prod[DIM*r] + prod[DIM*r+1] + prod[DIM*r+2];
    end
  end

  always_ff @(posedge clk) begin
    grad <= rsum[0] + rsum[1] + rsum[2];
  end

endmodule

// File: rtl/sobel_binarizer.sv
`timescale 1ns/1ps
module sobel_binarizer #(
  parameter int PIX_W  = 8,
  parameter int LINE_W = 640
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] pix_in,
  input  logic             pix_valid,
  input  logic             frame_start,
  input  logic             line_start,
  input  logic [PIX_W-1:0] thresh_in,
  output logic [PIX_W-1:0] mag_out,
  output logic             bin_out,
  output logic             out_valid
);

  localparam int COL_W   = $clog2(LINE_W);
  localparam int SUM_W   = PIX_W + 4;
  localparam int ABS_W   = SUM_W - 1;
  localparam int MAG_MAX = (1 << PIX_W) - 1;
  localparam int STAGES  = 5;

  logic [COL_W-1:0] col_q, col_n;
  logic [1:0]       row_q, row_n;
  logic             interior;

  always_comb begin
    col_n = col_q;
    row_n = row_q;
    if (frame_start) begin
      col_n = '0;
      row_n = '0;
    end else if (line_start) begin
      col_n = '0;
      row_n = (row_q == 2'd2) ? 2'd2 : row_q + 2'd1;
    end else if (col_q != COL_W'(LINE_W - 1)) begin
      col_n = col_q + COL_W'(1);
    end
  end

  assign interior = (row_n == 2'd2) && (col_n >= COL_W'(2));

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q <= '0;
      row_q <= '0;
    end else if (pix_valid) begin
      col_q <= col_n;
      row_q <= row_n;
    end
  end

  logic [STAGES:1] ok_pipe;
  logic [STAGES:1] sof_pipe;
  logic [PIX_W-1:0] thr_cap, thr_use;

  always_ff @(posedge clk) begin
    if (rst) begin
      ok_pipe  <= '0;
      sof_pipe <= '0;
      thr_cap  <= '0;
      thr_use  <= '0;
    end else begin
      ok_pipe  <= {ok_pipe[STAGES-1:1], pix_valid && interior};
      sof_pipe <= {sof_pipe[STAGES-1:1], pix_valid && frame_start};
      if (pix_valid && frame_start) thr_cap <= thresh_in;
      if (sof_pipe[STAGES])         thr_use <= thr_cap;
    end
  end

  logic [sobel_pkg::WIN_TAPS*PIX_W-1:0] win;

  sobel_window #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_window (
    .clk   (clk),
    .rst   (rst),
    .pix   (pix_in),
    .pix_v (pix_valid),
    .col   (col_n),
    .win   (win)
  );

  logic signed [SUM_W-1:0] gx, gy;

  sobel_grad #(.PIX_W(PIX_W), .DIR(sobel_pkg::GRAD_H)) u_grad_h (
    .clk  (clk),
    .win  (win),
    .grad (gx)
  );

  sobel_grad #(.PIX_W(PIX_W), .DIR(sobel_pkg::GRAD_V)) u_grad_v (
    .clk  (clk),
    .win  (win),
    .grad (gy)
  );

  logic [ABS_W-1:0] ax, ay;

  always_ff @(posedge clk) begin
    ax <= ABS_W'(gx[SUM_W-1] ? -gx : gx);
    ay <= ABS_W'(gy[SUM_W-1] ? -gy : gy);
  end

  logic [SUM_W-1:0] mag_raw;
  logic [PIX_W-1:0] mag_sat;

  assign mag_raw = {1'b0, ax} + {1'b0, ay};
  assign mag_sat = (mag_raw > SUM_W'(MAG_MAX)) ? PIX_W'(MAG_MAX) : mag_raw[PIX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      mag_out   <= '0;
      bin_out   <= 1'b0;
    end else begin
      out_valid <= ok_pipe[STAGES];
      mag_out   <= ok_pipe[STAGES] ? mag_sat : '0;
      bin_out   <= ok_pipe[STAGES] && (mag_sat > thr_use);
    end
  end

endmodule

// File: rtl/sobel_binarizer_chk.sv
`timescale 1ns/1ps
module sobel_binarizer_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             pix_valid,
  input logic             frame_start,
  input logic             line_start,
  input logic [PIX_W-1:0] mag_out,
  input logic             bin_out,
  input logic             out_valid
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (mag_out == '0) && !bin_out);  // R6

  AST_WHITE_NEEDS_MAG: assert property (@(posedge clk) disable iff (rst)
    bin_out |-> out_valid && (mag_out != '0));  // R4

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(pix_valid, 6));  // R7

  AST_FRAME_BORDER: assert property (@(posedge clk) disable iff (rst)
    $past(pix_valid && frame_start, 6) |-> !out_valid);  // R6

  AST_LINE_BORDER: assert property (@(posedge clk) disable iff (rst)
    $past(pix_valid && line_start, 6) |-> !out_valid);  // R8

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid && (mag_out == '0) && !bin_out);  // R9

endmodule

bind sobel_binarizer sobel_binarizer_chk #(.PIX_W(PIX_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pix_valid   (pix_valid),
  .frame_start (frame_start),
  .line_start  (line_start),
  .mag_out     (mag_out),
  .bin_out     (bin_out),
  .out_valid   (out_valid)
);

// File: tb/sobel_binarizer_test.sv
`timescale 1ns/1ps
module sobel_binarizer_test;

  localparam int PIX_W  = 8;
  localparam int LINE_W = 640;
  localparam int LAT    = 6;
  localparam int MAXR   = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [PIX_W-1:0] pix_in = '0;
  logic             pix_valid = 1'b0;
  logic             frame_start = 1'b0;
  logic             line_start = 1'b0;
  logic [PIX_W-1:0] thresh_in = '0;
  logic [PIX_W-1:0] mag_out;
  logic             bin_out;
  logic             out_valid;

  always #2.5 clk = ~clk;

  sobel_binarizer #(.PIX_W(PIX_W), .LINE_W(LINE_W)) uut (
    .clk         (clk),
    .rst         (rst),
    .pix_in      (pix_in),
    .pix_valid   (pix_valid),
    .frame_start (frame_start),
    .line_start  (line_start),
    .thresh_in   (thresh_in),
    .mag_out     (mag_out),
    .bin_out     (bin_out),
    .out_valid   (out_valid)
  );

  int img [MAXR][LINE_W];
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 1'b0;
  bit idle_bad = 1'b0;
  int cap_mag [$];
  int cap_bin [$];
  int cap_cyc [$];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        cap_mag.push_back(int'(mag_out));
        cap_bin.push_back(int'(bin_out));
        cap_cyc.push_back(cyc);
      end else if (mag_out != '0 || bin_out) begin
        idle_bad = 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ref_mag(input int r, input int c);
    int gx, gy, m;
    gx = (img[r-1][c+1] + 2*img[r][c+1] + img[r+1][c+1])
       - (img[r-1][c-1] + 2*img[r][c-1] + img[r+1][c-1]);
    gy = (img[r+1][c-1] + 2*img[r+1][c] + img[r+1][c+1])
       - (img[r-1][c-1] + 2*img[r-1][c] + img[r-1][c+1]);
    m = (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);
    return (m > 255) ? 255 : m;
  endfunction

  function automatic void fill_mix(input int rows, input int cols, input int seed);
    for (int r = 0; r < rows; r++)
      for (int c = 0; c < cols; c++)
        img[r][c] = (r*37 + c*91 + seed*13 + ((r*c + seed) % 29) * 7) % 256;
  endfunction

  task automatic drive_frame(input int rows, input int cols, input int thr0,
                             input int thr_after, input bit gaps, output int last_cyc);
    last_cyc = 0;
    for (int r = 0; r < rows; r++) begin
      for (int c = 0; c < cols; c++) begin
        if (gaps && ((r*cols + c) % 3 == 2)) begin
          @(negedge clk);
          pix_valid   = 1'b0;
          frame_start = 1'b0;
          line_start  = 1'b0;
          pix_in      = 8'hA5;
        end
        @(negedge clk);
        pix_valid   = 1'b1;
        pix_in      = PIX_W'(img[r][c]);
        frame_start = (r == 0 && c == 0);
        line_start  = (c == 0);
        thresh_in   = (r == 0 && c == 0) ? PIX_W'(thr0) : PIX_W'(thr_after);
        last_cyc    = cyc;
      end
    end
    @(negedge clk);
    pix_valid   = 1'b0;
    frame_start = 1'b0;
    line_start  = 1'b0;
    repeat (LAT + 4) @(negedge clk);
  endtask

  task automatic check_frame(input int rows, input int cols, input int thr, input string req);
    int exp_n, idx, m;
    exp_n = (rows >= 3 && cols >= 3) ? (rows-2)*(cols-2) : 0;
    chk(cap_mag.size() == exp_n, "R6 result count", cap_mag.size(), exp_n);
    idx = 0;
    for (int r = 1; r <= rows-2; r++) begin
      for (int c = 1; c <= cols-2; c++) begin
        if (idx < cap_mag.size()) begin
          m = ref_mag(r, c);
          chk(cap_mag[idx] == m, req, cap_mag[idx], m);
          chk(cap_bin[idx] == int'(m > thr), "R4 binary", cap_bin[idx], int'(m > thr));
        end
        idx++;
      end
    end
    chk(!idle_bad, "R6 idle outputs zero", int'(idle_bad), 0);
    cap_mag.delete();
    cap_bin.delete();
    cap_cyc.delete();
    idle_bad = 1'b0;
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R9 valid", int'(out_valid), 0);
    chk(mag_out == '0, "R9 mag", int'(mag_out), 0);
    chk(bin_out == 1'b0, "R9 bin", int'(bin_out), 0);
  endtask

  task automatic t_latency();
    int lc;
    fill_mix(3, 3, 1);
    drive_frame(3, 3, 50, 50, 1'b0, lc);
    chk(cap_cyc.size() == 1, "R7 one result", cap_cyc.size(), 1);
    if (cap_cyc.size() > 0)
      chk(cap_cyc[0] - lc == LAT, "R7 latency", cap_cyc[0] - lc, LAT);
    check_frame(3, 3, 50, "R1 magnitude");
  endtask

  task automatic t_threshold_edge(input int thr);
    int lc;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 6; c++)
        img[r][c] = (c >= 3) ? 10 : 0;
    drive_frame(4, 6, thr, thr, 1'b0, lc);
    // Magnitude 40 at the step: R4 strictness is decided there.
    if (cap_mag.size() > 1)
      chk(cap_mag[1] == 40 && cap_bin[1] == int'(40 > thr), "R4 equal threshold",
          cap_bin[1], int'(40 > thr));
    check_frame(4, 6, thr, "R1 step magnitude");
  endtask

  task automatic t_full_swing();
    int lc;
    for (int r = 0; r < 5; r++)
      for (int c = 0; c < 6; c++)
        img[r][c] = (c >= 3) ? 255 : 0;
    drive_frame(5, 6, 254, 254, 1'b0, lc);
    if (cap_mag.size() > 1)
      chk(cap_mag[1] == 255, "R3 saturation", cap_mag[1], 255);
    check_frame(5, 6, 254, "R2 positive full swing");
    for (int r = 0; r < 5; r++)
      for (int c = 0; c < 6; c++)
        img[r][c] = (r >= 2) ? 0 : 255;
    drive_frame(5, 6, 10, 10, 1'b0, lc);
    check_frame(5, 6, 10, "R2 negative full swing");
    for (int r = 0; r < 5; r++)
      for (int c = 0; c < 6; c++)
        img[r][c] = (r >= 2 && c >= 2) ? 255 : 0;
    drive_frame(5, 6, 200, 200, 1'b0, lc);
    check_frame(5, 6, 200, "R3 corner saturation");
  endtask

  task automatic t_gaps_and_threshold();
    int lc;
    fill_mix(6, 9, 3);
    drive_frame(6, 9, 100, 0, 1'b1, lc);
    check_frame(6, 9, 100, "R5 mid-frame threshold change, R8 gaps");
    drive_frame(6, 9, 0, 0, 1'b0, lc);
    check_frame(6, 9, 0, "R5 next frame threshold");
  endtask

  task automatic t_restart();
    int lc;
    fill_mix(2, 9, 5);
    drive_frame(2, 9, 77, 77, 1'b0, lc);
    chk(cap_mag.size() == 0, "R8 truncated frame", cap_mag.size(), 0);
    fill_mix(4, 9, 6);
    drive_frame(4, 9, 90, 90, 1'b0, lc);
    check_frame(4, 9, 90, "R8 frame restart");
  endtask

  task automatic t_full_width();
    int lc;
    fill_mix(4, LINE_W, 9);
    drive_frame(4, LINE_W, 128, 128, 1'b0, lc);
    check_frame(4, LINE_W, 128, "R10 full width");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 200000);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_latency();
    t_threshold_edge(40);
    t_threshold_edge(39);
    t_full_swing();
    t_gaps_and_threshold();
    t_restart();
    t_full_width();
    finish_run();
  end

endmodule